// File: doc/BRIEF.md
# Performance Mode Clock Rate Selector

This block turns one fast base clock into a set of clock-enable strobes, one per clock domain of a system: the processor, the external and shared memory path, the interconnect peripherals (DMA, NAND and graphics), the fast peripheral bridge and the slow peripheral bridge. Software writes a performance mode into a control register. Each domain then gets a divide ratio from a fixed, non-uniform table. The fabric runs from the base clock, which stands for the 208 MHz PLL. An always-on 13 MHz source reaches the block as a one-cycle qualifier, `aonTick`.

In low-power mode, and whenever the base PLL is not locked, every domain is paced from the always-on qualifier instead of the base clock. A power-management enable bit lets low-power mode turn the base PLL off. A status register reports the PLL lock indication, the mode now in force and the active source. A new mode or source takes effect only on a common boundary where every strobe fires together, so no domain ever sees a shortened period.

Top module: `perf_clk_sel`

## Requirements
- R1: After reset the mode request, the power-management bit and the applied mode all read 0 (best). The active source is the always-on qualifier, and `pllOn` is 1.
- R2: Mode codes in the 3-bit request field are: 0 best, 1 high, 2 intermediate, 3 low, 4 low-power. Codes 5 to 7 are applied as best, and the status register then reports applied mode 0. The request field still reads back the raw code.
- R3: On the base source, each domain strobes once every 2^e base cycles. The exponents e for CPU, memory, interconnect, fast and slow are: best 0,1,2,3,4; high 1,1,2,3,4; intermediate 2,2,3,3,4; low 4,4,5,4,4.
- R4: A 5-bit pacing counter advances on every pacing event. A new mode and source are taken only on the event where the counter is 31, which is the event where all strobes fire. They apply from the next cycle, and the strobe pattern between such events follows the old configuration.
- R5: On the always-on source, the pacing event is `aonTick`. CPU, memory, fast and slow strobe on every such tick, and interconnect strobes on every second tick. No strobe is asserted in a cycle without `aonTick`.
- R6: At a boundary, the source becomes the always-on qualifier if the applied mode is low-power or the registered lock is low. Otherwise it becomes the base clock.
- R7: Status bit 0 shows `pllLock` delayed by one cycle. This registered value is the one R6 uses.
- R8: The register map is: address 0 holds the mode request in bits 2:0; address 1 holds the power-management enable in bit 0; address 2 holds status, with the applied mode in bits 4:2, the always-on source flag in bit 1 and lock in bit 0; address 3 reads 0. Unused bits read 0, and writes to addresses 2 and 3 change nothing.
- R9: `pllOn` is 0 exactly when the power-management enable is set and the applied mode is low-power.
- R10: The slow domain strobes at 13 MHz in every configuration: every 16 base cycles, or on every `aonTick`. Whenever it fires, the CPU, memory and fast strobes fire too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock (stands for the 208 MHz PLL output) |
| rst | input | 1 | Synchronous active-high reset |
| aonTick | input | 1 | One-cycle qualifier per period of the always-on 13 MHz source |
| pllLock | input | 1 | Lock indication of the base PLL |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register write address |
| wrData | input | DATA_W | Register write data |
| rdAddr | input | 2 | Register read address |
| rdData | output | DATA_W | Register read data (combinational) |
| domStb | output | 5 | Domain strobes: bit 0 CPU, 1 memory, 2 interconnect, 3 fast, 4 slow |
| pllOn | output | 1 | Base PLL power request |

## Verification
The bench walks through every mode code. Running all four base-source modes separates the table rows, because each mode differs from its neighbours in at least one domain's ratio. A reserved code shows whether unknown values fall back to best. The always-on source is reached in two ways: through low-power mode and through a lost lock with best requested. This checks that both the mode and the lock select the source, and that the interconnect halving persists on that source. A mode write placed right after an all-strobes cycle in low mode must leave the old mode in force for the full 31 following cycles. That shows whether changes wait for the boundary or take effect at once.

// File: rtl/rate_sel_pkg.sv
`timescale 1ns/1ps
package rate_sel_pkg;

  localparam int NUM_DOM = 5;
  localparam int EXP_W   = 3;
  localparam int MAX_EXP = 5;
  localparam int MODE_W  = 3;
  localparam int ADDR_W  = 2;

  localparam int DOM_CPU  = 0;
  localparam int DOM_MEM  = 1;
  localparam int DOM_IC   = 2;
  localparam int DOM_FAST = 3;
  localparam int DOM_SLOW = 4;

  typedef enum logic [MODE_W-1:0] {
    MODE_BEST = 3'd0,
    MODE_HIGH = 3'd1,
    MODE_MID  = 3'd2,
    MODE_LOW  = 3'd3,
    MODE_LP   = 3'd4
  } perfMode_e;

  // control -> datapath: pacing strobe plus per-domain divide exponents
  typedef struct packed {
    logic                             adv;
    logic                             useAon;
    logic [NUM_DOM-1:0][EXP_W-1:0]    divExp;
  } divCmd_t;

  function automatic perfMode_e normMode(input logic [MODE_W-1:0] raw);
    perfMode_e m;
    case (raw)
      3'd1:    m = MODE_HIGH;
      3'd2:    m = MODE_MID;
      3'd3:    m = MODE_LOW;
      3'd4:    m = MODE_LP;
      default: m = MODE_BEST;
    endcase
    return m;
  endfunction

  function automatic logic [EXP_W-1:0] domExp(input perfMode_e m, input logic aon,
                                              input int d);
    logic [EXP_W-1:0] r;
    if (aon || m == MODE_LP) begin
      r = (d == DOM_IC) ? EXP_W'(1) : EXP_W'(0);
    end else begin
      case (m)
        MODE_HIGH: r = (d == DOM_CPU || d == DOM_MEM) ? EXP_W'(1) :
                       (d == DOM_IC)   ? EXP_W'(2) :
                       (d == DOM_FAST) ? EXP_W'(3) : EXP_W'(4);
        MODE_MID:  r = (d == DOM_IC || d == DOM_FAST) ? EXP_W'(3) :
                       (d == DOM_SLOW) ? EXP_W'(4) : EXP_W'(2);
        MODE_LOW:  r = (d == DOM_IC) ? EXP_W'(MAX_EXP) : EXP_W'(4);
        default:   r = EXP_W'(d);
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/rate_ctrl.sv
`timescale 1ns/1ps
module rate_ctrl
  import rate_sel_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              aonTick,
  input  logic              pllLock,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic              boundary,
  output divCmd_t           cmd,
  output logic              pllOn
);

  localparam int STAT_W = MODE_W + 2;

  logic [MODE_W-1:0] modeReq;
  logic              pmEn;
  logic              lockQ;
  perfMode_e         applied;
  logic              useAon;
  perfMode_e         nextMode;

  assign nextMode = normMode(modeReq);

  always_ff @(posedge clk) begin
    if (rst) begin
      modeReq <= '0;
      pmEn    <= 1'b0;
      lockQ   <= 1'b0;
      applied <= MODE_BEST;
      useAon  <= 1'b1;
    end else begin
      lockQ <= pllLock;
      if (wrEn) begin
        case (wrAddr)
          ADDR_W'(0): modeReq <= wrData[MODE_W-1:0];
          ADDR_W'(1): pmEn    <= wrData[0];
          default:    ;
        endcase
      end
      if (boundary) begin
        applied <= nextMode;
        useAon  <= (nextMode == MODE_LP) || !lockQ;
      end
    end
  end

  always_comb begin
    rdData = '0;
    case (rdAddr)
      ADDR_W'(0): rdData[MODE_W-1:0] = modeReq;
      ADDR_W'(1): rdData[0]          = pmEn;
      ADDR_W'(2): rdData[STAT_W-1:0] = {applied, useAon, lockQ};
      default:    rdData = '0;
    endcase
  end

  assign cmd.adv    = useAon ? aonTick : 1'b1;
  assign cmd.useAon = useAon;

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_exp
    assign cmd.divExp[d] = domExp(applied, useAon, d);
  end

  assign pllOn = !(pmEn && applied == MODE_LP);

  // R4: configuration only moves on a boundary from the datapath
  assert_cfg_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> ($stable(applied) && $stable(useAon)));

  // R6: low-power mode is always paced from the always-on source
  assert_lp_aon_R6: assert property (@(posedge clk) disable iff (rst)
    (applied == MODE_LP) |-> useAon);

  // R6: an unlocked PLL at a boundary forces the always-on source
  assert_unlocked_aon_R6: assert property (@(posedge clk) disable iff (rst)
    (boundary && !lockQ) |=> useAon);

  // R9: the PLL is only turned off in low-power mode
  assert_pll_on_R9: assert property (@(posedge clk) disable iff (rst)
    !pllOn |-> (applied == MODE_LP));

endmodule

// File: rtl/rate_div.sv
`timescale 1ns/1ps
module rate_div
  import rate_sel_pkg::*;
#(
  parameter int CNT_W = MAX_EXP
) (
  input  logic               clk,
  input  logic               rst,
  input  divCmd_t            cmd,
  output logic [NUM_DOM-1:0] stb,
  output logic               boundary
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (cmd.adv) cnt <= cnt + 1'b1;
  end

  assign boundary = cmd.adv && (&cnt);

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    logic [CNT_W-1:0] mask;
    assign mask   = ~({CNT_W{1'b1}} << cmd.divExp[d]);
    assign stb[d] = cmd.adv && ((cnt & mask) == mask);
  end

  // R4: the counter holds between pacing events
  assert_cnt_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !cmd.adv |=> $stable(cnt));

endmodule

// File: rtl/perf_clk_sel.sv
`timescale 1ns/1ps
module perf_clk_sel
  import rate_sel_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               aonTick,
  input  logic               pllLock,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [DATA_W-1:0]  rdData,
  output logic [NUM_DOM-1:0] domStb,
  output logic               pllOn
);

  localparam int CNT_W = MAX_EXP;

  divCmd_t cmd;
  logic    boundary;

  rate_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .aonTick  (aonTick),
    .pllLock  (pllLock),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .rdAddr   (rdAddr),
    .rdData   (rdData),
    .boundary (boundary),
    .cmd      (cmd),
    .pllOn    (pllOn)
  );

  rate_div #(.CNT_W(CNT_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .cmd      (cmd),
    .stb      (domStb),
    .boundary (boundary)
  );

  // R5: on the always-on source nothing strobes between ticks
  assert_aon_idle_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd.useAon && !aonTick) |-> (domStb == '0));

  // R10: a slow strobe always coincides with the CPU, memory and fast strobes
  assert_slow_nest_R10: assert property (@(posedge clk) disable iff (rst)
    domStb[DOM_SLOW] |-> (domStb[DOM_CPU] && domStb[DOM_MEM] && domStb[DOM_FAST]));

endmodule

// File: tb/perf_clk_sel_test.sv
`timescale 1ns/1ps
module perf_clk_sel_test;

  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              aonTick = 1'b0;
  logic              pllLock = 1'b0;
  logic              wrEn = 1'b0;
  logic [1:0]        wrAddr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic [1:0]        rdAddr = 2'd2;
  logic [DATA_W-1:0] rdData;
  logic [4:0]        domStb;
  logic              pllOn;

  int checks = 0;
  int fails  = 0;

  perf_clk_sel #(.DATA_W(DATA_W)) uut (
    .clk(clk), .rst(rst), .aonTick(aonTick), .pllLock(pllLock),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr),
    .rdData(rdData), .domStb(domStb), .pllOn(pllOn)
  );

  always #10 clk = ~clk;

  // always-on 13 MHz source: one tick every 16 base cycles
  int aonDiv = 0;
  always @(posedge clk) begin
    #1;
    aonDiv  = (aonDiv + 1) % 16;
    aonTick = (aonDiv == 0);
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int baseTab [4][5] = '{'{0,1,2,3,4}, '{1,1,2,3,4}, '{2,2,3,3,4}, '{4,4,5,4,4}};
  int mCnt = 0, mApplied = 0, mModeReq = 0;
  bit mAon = 1, mPm = 0, mLockQ = 0;
  bit cmpOn = 0;

  function automatic int normM(input int m);
    return (m > 4) ? 0 : m;
  endfunction

  function automatic int expOf(input int m, input bit aon, input int d);
    if (aon || m == 4) return (d == 2) ? 1 : 0;
    return baseTab[m][d];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mCnt = 0; mApplied = 0; mModeReq = 0; mAon = 1; mPm = 0; mLockQ = 0;
    end else begin
      int nm;
      bit lk, adv, bnd;
      nm  = normM(mModeReq);
      lk  = mLockQ;
      adv = mAon ? aonTick : 1'b1;
      bnd = adv && (mCnt == 31);
      mLockQ = pllLock;
      if (wrEn && wrAddr == 2'd0) mModeReq = int'(wrData[2:0]);
      if (wrEn && wrAddr == 2'd1) mPm = wrData[0];
      if (adv) mCnt = (mCnt + 1) % 32;
      if (bnd) begin
        mApplied = nm;
        mAon     = (nm == 4) || !lk;
      end
    end
  end

  always @(negedge clk) begin
    if (cmpOn) begin
      logic [4:0] eStb;
      int eRd;
      bit adv;
      adv = mAon ? aonTick : 1'b1;
      for (int d = 0; d < 5; d++) begin
        int dv;
        dv = 1 << expOf(mApplied, mAon, d);
        eStb[d] = adv && ((mCnt % dv) == dv - 1);
      end
      case (rdAddr)
        2'd0: eRd = mModeReq;
        2'd1: eRd = int'(mPm);
        2'd2: eRd = (mApplied << 2) | (int'(mAon) << 1) | int'(mLockQ);
        default: eRd = 0;
      endcase
      chk(domStb == eStb, mAon ? "R5 strobes" : "R3 strobes", int'(domStb), int'(eStb));
      chk(domStb[4] == eStb[4], "R10 slow strobe", int'(domStb[4]), int'(eStb[4]));
      chk(int'(rdData) == eRd, "R8 readback", int'(rdData), eRd);
      chk(pllOn == !(mPm && mApplied == 4), "R9 pllOn", int'(pllOn), int'(!(mPm && mApplied == 4)));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(input int a, input int v);
    @(posedge clk); #2;
    wrEn = 1'b1; wrAddr = 2'(a); wrData = DATA_W'(v);
    @(posedge clk); #2;
    wrEn = 1'b0;
  endtask

  task automatic rdChk(input int a, input int exp, input string tag);
    @(posedge clk); #2;
    rdAddr = 2'(a);
    @(negedge clk);
    chk(int'(rdData) == exp, tag, int'(rdData), exp);
  endtask

  task automatic countWin(input int n, output int c [5], output int ticks);
    for (int d = 0; d < 5; d++) c[d] = 0;
    ticks = 0;
    repeat (n) begin
      @(negedge clk);
      if (aonTick) ticks++;
      for (int d = 0; d < 5; d++) if (domStb[d]) c[d]++;
    end
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int c [5];
    int tk;
    idle(5);
    rst = 1'b0;
    cmpOn = 1'b1;

    // R1: reset state
    rdChk(2, 2, "R1 status after reset");
    rdChk(0, 0, "R1 mode request after reset");
    rdChk(1, 0, "R1 pm enable after reset");
    @(negedge clk); chk(pllOn == 1'b1, "R1 pllOn after reset", int'(pllOn), 1);

    // lock arrives; move to base source at the first boundary
    pllLock = 1'b1;
    idle(600);
    rdChk(2, 1, "R7 status locked best on base");

    // R3: best mode ratios
    countWin(320, c, tk);
    chk(c[0] == 320, "R3 best cpu count", c[0], 320);
    chk(c[1] == 160, "R3 best mem count", c[1], 160);
    chk(c[2] == 80,  "R3 best ic count",  c[2], 80);
    chk(c[3] == 40,  "R3 best fast count", c[3], 40);
    chk(c[4] == 20,  "R10 base slow count", c[4], 20);

    wr(0, 1); idle(100);
    rdChk(2, (1 << 2) | 1, "R2 high applied");
    countWin(320, c, tk);
    chk(c[0] == 160, "R3 high cpu count", c[0], 160);

    wr(0, 2); idle(100);
    countWin(320, c, tk);
    chk(c[2] == 40, "R3 intermediate ic count", c[2], 40);
    chk(c[1] == 80, "R3 intermediate mem count", c[1], 80);

    wr(0, 3); idle(100);
    countWin(320, c, tk);
    chk(c[2] == 10, "R3 low ic count", c[2], 10);
    chk(c[4] == 20, "R10 low slow count", c[4], 20);

    // R4: write right after an all-strobes cycle; old mode holds 31 cycles
    rdAddr = 2'd2;
    @(negedge clk);
    while (domStb != 5'h1f) @(negedge clk);
    @(posedge clk); #2;
    wrEn = 1'b1; wrAddr = 2'd0; wrData = DATA_W'(0);
    @(posedge clk); #2;
    wrEn = 1'b0;
    idle(10);
    @(negedge clk);
    chk(int'(rdData) == ((3 << 2) | 1), "R4 old mode holds before boundary", int'(rdData), (3 << 2) | 1);
    idle(40);
    rdChk(2, 1, "R4 new mode after boundary");

    // R2: reserved code behaves as best, raw code readable
    wr(0, 6); idle(100);
    rdChk(2, 1, "R2 reserved applied as best");
    rdChk(0, 6, "R2 raw code readback");

    // R8: writes to status and spare address ignored
    wr(2, 16'hffff); wr(3, 16'hffff);
    rdChk(2, 1, "R8 status write ignored");
    rdChk(3, 0, "R8 spare address reads zero");

    // R9 / R5: low-power with power management enabled
    wr(1, 1);
    wr(0, 4); idle(100);
    rdChk(2, (4 << 2) | 2 | 1, "R6 low-power on always-on source");
    @(negedge clk); chk(pllOn == 1'b0, "R9 pll off in low-power", int'(pllOn), 0);
    countWin(320, c, tk);
    chk(c[0] == tk, "R5 cpu per tick", c[0], tk);
    chk(c[2] * 2 == tk, "R5 ic every second tick", c[2] * 2, tk);
    chk(c[4] == 20, "R10 always-on slow count", c[4], 20);

    // R6: best requested but lock lost -> stay on always-on source
    pllLock = 1'b0;
    wr(0, 0); idle(600);
    rdChk(2, 2, "R6 unlocked stays on always-on source");
    @(negedge clk); chk(pllOn == 1'b1, "R9 pll on outside low-power", int'(pllOn), 1);
    pllLock = 1'b1;
    idle(2);
    rdChk(2, 3, "R7 lock visible in status");
    idle(600);
    rdChk(2, 1, "R6 relock returns to base");

    cmpOn = 1'b0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule